// File: doc/BRIEF.md
# Multi-Domain Clock-Enable Divider

This unit turns one source clock into six clock-enable streams. Four of them pace the processor core, the fast system bus, the slow peripheral bus and the memory controller. A fifth paces the display controller. The sixth is a pixel-rate enable with a wide ratio range. Each stream is a one-cycle pulse of the source clock that repeats every N cycles. Downstream logic stays on the source clock and qualifies its registers with the pulse.

Software programs a control word that holds one 4-bit ratio code per table-driven domain. Each code selects a divide ratio from a fixed, non-power-of-two list. New codes wait in shadow storage until software sets a commit bit. After the commit, each domain moves to its new ratio only at the end of its current period, so no period is ever cut short. A second register holds the pixel ratio directly. When the `pll_en` input is low, the processor, both bus and the memory enables run at the full source rate. The display and pixel enables are not affected by `pll_en`.

Top module: `clkdiv_unit`

## Requirements
- R1: A ratio code from 0 to 9 selects a divide ratio from the list 1, 2, 3, 4, 6, 8, 12, 16, 24, 32, in code order.
- R2: A ratio code of 10 to 15 divides by 1.
- R3: The control word (`reg_sel`=0) places the ratio codes as follows:
  - processor at bits 3:0
  - fast bus at 7:4
  - slow bus at 11:8
  - display at 15:12
  - memory at 19:16

  Reading the control word returns these fields as they were written.
- R4: A control write with bit 20 clear only updates the shadow fields. The enable outputs keep their current ratio.
- R5: A control write with bit 20 set commits all five shadow fields. Bit 20 reads back as 1 in the cycle after the write and as 0 from the cycle after that, unless the commit is written again.
- R6: A committed ratio takes effect only at the domain's next terminal count. Every gap between pulses equals either the old ratio or the new ratio.
- R7: While `pll_en` is low, `cpu_ce`, `fbus_ce`, `sbus_ce` and `mem_ce` are held high. `lcd_ce` and `pix_ce` keep their programmed ratio.
- R8: For ratio N, an enable is high for one cycle out of every N cycles. For N=1 it stays high.
- R9: A pixel write (`reg_sel`=1) treats bits 15:0 as the requested ratio.
  - A request of 0 is stored as ratio 1; a request above 512 is stored as ratio 512.
  - Bits 8:0 of the pixel register read back as the ratio minus one.
  - The new pixel ratio takes effect at the pixel divider's next terminal count, with no commit bit.
- R10: After synchronous reset:
  - both registers read 0
  - every ratio is 1
  - every enable is high

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rst | input | 1 | Synchronous reset, active high |
| pll_en | input | 1 | Low forces the four system-domain enables high |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the control word, 1 selects the pixel register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the register picked by `reg_sel` (combinational) |
| cpu_ce | output | 1 | Processor clock enable |
| fbus_ce | output | 1 | Fast bus clock enable |
| sbus_ce | output | 1 | Slow bus clock enable |
| lcd_ce | output | 1 | Display device clock enable |
| mem_ce | output | 1 | Memory clock enable |
| pix_ce | output | 1 | Pixel clock enable |

## Verification
The in-design properties rely on three conditions:
- reset is asserted before the first clock edge;
- every ratio handed to a divider counter is nonzero, which the ratio list and the minus-one pixel encoding guarantee;
- `pll_en` behaves as a level that only masks the outputs and never disturbs the counters.

The stimulus follows these conditions. It holds reset for several cycles, drives writes and `pll_en` only between clock edges, and lets each new ratio settle for longer than the largest old period before it counts pulses.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
   localparam int TAB_RW   = 6;   // wide enough for the largest list ratio (32)
   localparam int CODE_MAX = 8;   // widest ratio code the list function accepts

   function automatic logic [TAB_RW-1:0] code_to_ratio(input logic [CODE_MAX-1:0] code);
      case (code)
         8'd0:    return 6'd1;
         8'd1:    return 6'd2;
         8'd2:    return 6'd3;
         8'd3:    return 6'd4;
         8'd4:    return 6'd6;
         8'd5:    return 6'd8;
         8'd6:    return 6'd12;
         8'd7:    return 6'd16;
         8'd8:    return 6'd24;
         8'd9:    return 6'd32;
         default: return 6'd1;  // codes past the list fall back to divide-by-1
      endcase
   endfunction
endpackage

// File: rtl/clkdiv_lut.sv
module clkdiv_lut
   import clkdiv_pkg::*;
#(
   parameter int IDX_W = 4
) (
   input  logic [IDX_W-1:0]  code,
   output logic [TAB_RW-1:0] ratio
);
   if (IDX_W < 4 || IDX_W > CODE_MAX) begin : g_bad_idx
      $error("clkdiv_lut: IDX_W out of range");
   end

   always_comb ratio = code_to_ratio(CODE_MAX'(code));
endmodule

// File: rtl/clkdiv_core.sv
module clkdiv_core #(
   parameter int RW = 6
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          bypass,
   input  logic          load,
   input  logic [RW-1:0] ratio_req,
   output logic          ce
);
   if (RW < 1) begin : g_bad_rw
      $error("clkdiv_core: RW must be positive");
   end

   logic [RW-1:0] act_q, pend_q, cnt_q;
   logic          pend_v_q;
   logic          tc;

   assign tc = (cnt_q == act_q - 1'b1);
   assign ce = bypass | tc;

   always_ff @(posedge clk) begin
      if (rst) begin
         act_q    <= RW'(1);
         pend_q   <= RW'(1);
         pend_v_q <= 1'b0;
         cnt_q    <= '0;
      end else begin
         if (tc) begin
            cnt_q <= '0;
            if (pend_v_q) begin
               act_q    <= pend_q;
               pend_v_q <= 1'b0;
            end
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
         if (load) begin
            pend_q   <= ratio_req;
            pend_v_q <= 1'b1;
         end
      end
   end

   // R6: active ratio moves only at a terminal count
   a_r6_switch_at_tc: assert property (@(posedge clk) disable iff (rst)
      !tc |=> $stable(act_q));
   // R6: with no switch pending, a pulse at ratio above 1 is never followed by another at once
   a_r6_no_runt: assert property (@(posedge clk) disable iff (rst)
      (tc && act_q != RW'(1) && !pend_v_q) |=> !tc);
   // R8: the count stays inside the period
   a_r8_cnt_bound: assert property (@(posedge clk) disable iff (rst)
      cnt_q < act_q);
endmodule

// File: rtl/clkdiv_regs.sv
module clkdiv_regs #(
   parameter int FW      = 20,
   parameter int UPD_BIT = 20,
   parameter int PIX_W   = 9,
   parameter int REQ_W   = 16,
   parameter int DATA_W  = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              reg_wr,
   input  logic              reg_sel,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic [FW-1:0]     shadow,
   output logic              commit,
   output logic [PIX_W-1:0]  pix_field,
   output logic              pix_load
);
   localparam logic [REQ_W-1:0] PIX_MAX = REQ_W'(1) << PIX_W;
   localparam logic [PIX_W-1:0] PIX_TOP = '1;

   if (UPD_BIT < FW || UPD_BIT >= DATA_W || REQ_W <= PIX_W || REQ_W > DATA_W) begin : g_bad_map
      $error("clkdiv_regs: inconsistent register layout");
   end

   logic [REQ_W-1:0] req, lim;
   logic             ctl_wr, pix_wr;

   assign req    = reg_wdata[REQ_W-1:0];
   assign ctl_wr = reg_wr && !reg_sel;
   assign pix_wr = reg_wr && reg_sel;

   always_comb begin
      if (req == '0)          lim = '0;
      else if (req > PIX_MAX) lim = PIX_MAX - 1'b1;
      else                    lim = req - 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         shadow    <= '0;
         commit    <= 1'b0;
         pix_field <= '0;
         pix_load  <= 1'b0;
      end else begin
         commit   <= ctl_wr && reg_wdata[UPD_BIT];
         pix_load <= pix_wr;
         if (ctl_wr) shadow    <= reg_wdata[FW-1:0];
         if (pix_wr) pix_field <= lim[PIX_W-1:0];
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_sel) begin
         reg_rdata[PIX_W-1:0] = pix_field;
      end else begin
         reg_rdata[FW-1:0]    = shadow;
         reg_rdata[UPD_BIT]   = commit;
      end
   end

   // R5: commit flag clears by itself unless written again
   a_r5_selfclear: assert property (@(posedge clk) disable iff (rst)
      (commit && !(ctl_wr && reg_wdata[UPD_BIT])) |=> !commit);
   // R9: request of zero stores ratio 1
   a_r9_clamp_low: assert property (@(posedge clk) disable iff (rst)
      (pix_wr && req == '0) |=> pix_field == '0);
   // R9: oversized request stores the largest ratio
   a_r9_clamp_high: assert property (@(posedge clk) disable iff (rst)
      (pix_wr && req > PIX_MAX) |=> pix_field == PIX_TOP);
endmodule

// File: rtl/clkdiv_unit.sv
module clkdiv_unit
   import clkdiv_pkg::*;
#(
   parameter int IDX_W   = 4,
   parameter int UPD_BIT = 20,
   parameter int PIX_W   = 9,
   parameter int REQ_W   = 16,
   parameter int DATA_W  = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              pll_en,
   input  logic              reg_wr,
   input  logic              reg_sel,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              cpu_ce,
   output logic              fbus_ce,
   output logic              sbus_ce,
   output logic              lcd_ce,
   output logic              mem_ce,
   output logic              pix_ce
);
   localparam int NUM_TAB  = 5;   // slot order: cpu, fbus, sbus, lcd, mem
   localparam int LCD_SLOT = 3;
   localparam int FW       = NUM_TAB * IDX_W;
   localparam int PIX_RW   = PIX_W + 1;

   if (FW > UPD_BIT) begin : g_bad_fields
      $error("clkdiv_unit: ratio fields overlap the commit bit");
   end

   logic [FW-1:0]      shadow;
   logic               commit, pix_load;
   logic [PIX_W-1:0]   pix_field;
   logic [PIX_RW-1:0]  pix_ratio;
   logic [NUM_TAB-1:0] tab_ce;

   clkdiv_regs #(
      .FW(FW), .UPD_BIT(UPD_BIT), .PIX_W(PIX_W), .REQ_W(REQ_W), .DATA_W(DATA_W)
   ) u_regs (
      .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .shadow(shadow),
      .commit(commit), .pix_field(pix_field), .pix_load(pix_load)
   );

   for (genvar d = 0; d < NUM_TAB; d++) begin : g_dom
      logic [TAB_RW-1:0] ratio;
      logic              byp;

      if (d == LCD_SLOT) begin : g_nobyp
         assign byp = 1'b0;
      end else begin : g_byp
         assign byp = !pll_en;
      end

      clkdiv_lut #(.IDX_W(IDX_W)) u_lut (
         .code(shadow[d*IDX_W +: IDX_W]), .ratio(ratio)
      );

      clkdiv_core #(.RW(TAB_RW)) u_core (
         .clk(clk), .rst(rst), .bypass(byp), .load(commit),
         .ratio_req(ratio), .ce(tab_ce[d])
      );
   end

   assign pix_ratio = {1'b0, pix_field} + PIX_RW'(1);

   clkdiv_core #(.RW(PIX_RW)) u_pix (
      .clk(clk), .rst(rst), .bypass(1'b0), .load(pix_load),
      .ratio_req(pix_ratio), .ce(pix_ce)
   );

   assign cpu_ce  = tab_ce[0];
   assign fbus_ce = tab_ce[1];
   assign sbus_ce = tab_ce[2];
   assign lcd_ce  = tab_ce[LCD_SLOT];
   assign mem_ce  = tab_ce[4];
endmodule

// File: tb/sim_clkdiv_unit.sv
`timescale 1ns/1ps
module sim_clkdiv_unit;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        pll_en = 1'b1;
   logic        reg_wr = 1'b0;
   logic        reg_sel = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        cpu_ce, fbus_ce, sbus_ce, lcd_ce, mem_ce, pix_ce;
   logic [5:0]  cev;

   int n_chk = 0;
   int n_fail = 0;
   int cnt [6];
   bit finished = 0;

   // vector table: {ratio code, expected ratio}
   localparam int VEC [16][2] = '{
      '{0, 1}, '{1, 2}, '{2, 3}, '{3, 4}, '{4, 6}, '{5, 8}, '{6, 12}, '{7, 16},
      '{8, 24}, '{9, 32}, '{10, 1}, '{11, 1}, '{12, 1}, '{13, 1}, '{14, 1}, '{15, 1}};

   always #2.5 clk = ~clk;

   clkdiv_unit u0 (
      .clk(clk), .rst(rst), .pll_en(pll_en), .reg_wr(reg_wr), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_ce(cpu_ce), .fbus_ce(fbus_ce),
      .sbus_ce(sbus_ce), .lcd_ce(lcd_ce), .mem_ce(mem_ce), .pix_ce(pix_ce)
   );

   // slot order: 0 cpu, 1 fbus, 2 sbus, 3 lcd, 4 mem, 5 pix
   assign cev = {pix_ce, mem_ce, lcd_ce, sbus_ce, fbus_ce, cpu_ce};

   task automatic chk(input string tag, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic wr(input logic sel, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic sel, output logic [31:0] d);
      reg_sel = sel;
      #0.5 d = reg_rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic count96();
      for (int k = 0; k < 6; k++) cnt[k] = 0;
      for (int c = 0; c < 96; c++) begin
         @(negedge clk);
         for (int k = 0; k < 6; k++) if (cev[k]) cnt[k]++;
      end
   endtask

   task automatic pix_gap(output int g);
      int t = 0;
      while (!pix_ce && t < 2000) begin @(negedge clk); t++; end
      g = 0;
      do begin @(negedge clk); g++; end while (!pix_ce && g < 2000);
   endtask

   // every gap between cpu pulses in a window must be one of two values
   task automatic gap_scan(input int a, input int b, output int bad);
      int last = -1;
      bad = 0;
      for (int c = 0; c < 200; c++) begin
         @(negedge clk);
         if (cpu_ce) begin
            if (last >= 0 && (c - last) != a && (c - last) != b) bad++;
            last = c;
         end
      end
   endtask

   function automatic logic [31:0] all_codes(input int code);
      logic [31:0] v = '0;
      for (int d = 0; d < 5; d++) v |= 32'(code) << (4 * d);
      return v;
   endfunction

   initial begin
      logic [31:0] r;
      int g, bad;
      repeat (4) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);

      // R10: reset state
      rd(1'b0, r); chk("R10", "ctrl after reset", int'(r), 0);
      rd(1'b1, r); chk("R10", "pixel after reset", int'(r), 0);
      count96();
      for (int k = 0; k < 6; k++) chk("R10", "enable count after reset", cnt[k], 96);

      // R1 / R2 / R8: table walk, all five fields carry the same code
      for (int i = 0; i < 16; i++) begin
         wr(1'b0, all_codes(VEC[i][0]) | 32'h0010_0000);
         idle(40);
         count96();
         for (int k = 0; k < 5; k++)
            chk(VEC[i][0] < 10 ? "R1_R8" : "R2", "pulses per 96", cnt[k], 96 / VEC[i][1]);
      end

      // R4: shadow write without commit leaves outputs alone
      wr(1'b0, 32'h0);
      wr(1'b0, 32'h0010_0000);
      idle(40);
      wr(1'b0, 32'h0005_4321);
      rd(1'b0, r); chk("R3", "ctrl readback", int'(r), 32'h0005_4321);
      idle(40);
      count96();
      for (int k = 0; k < 5; k++) chk("R4", "no change before commit", cnt[k], 96);

      // R5: commit flag reads 1 once, then 0
      wr(1'b0, 32'h0015_4321);
      rd(1'b0, r); chk("R5", "commit flag first cycle", int'(r), 32'h0015_4321);
      @(negedge clk);
      rd(1'b0, r); chk("R5", "commit flag cleared", int'(r), 32'h0005_4321);

      // R3: distinct codes land in distinct domains
      idle(40);
      count96();
      chk("R3", "cpu ratio 2", cnt[0], 48);
      chk("R3", "fbus ratio 3", cnt[1], 32);
      chk("R3", "sbus ratio 4", cnt[2], 24);
      chk("R3", "lcd ratio 6", cnt[3], 16);
      chk("R3", "mem ratio 8", cnt[4], 12);

      // R7: source-rate mode
      pll_en = 1'b0;
      count96();
      chk("R7", "cpu bypass", cnt[0], 96);
      chk("R7", "fbus bypass", cnt[1], 96);
      chk("R7", "sbus bypass", cnt[2], 96);
      chk("R7", "mem bypass", cnt[4], 96);
      chk("R7", "lcd unaffected", cnt[3], 16);
      pll_en = 1'b1;
      count96();
      chk("R7", "cpu back to ratio 2", cnt[0], 48);

      // R6: ratio change lands on a period boundary, both directions
      wr(1'b0, 32'h0010_0009);
      idle(40);
      wr(1'b0, 32'h0010_0003);
      gap_scan(32, 4, bad);
      chk("R6", "gaps 32 to 4", bad, 0);
      wr(1'b0, 32'h0010_0009);
      gap_scan(4, 32, bad);
      chk("R6", "gaps 4 to 32", bad, 0);

      // R9: pixel ratio encoding and clamping
      wr(1'b1, 32'd0);
      rd(1'b1, r); chk("R9", "pixel req 0 field", int'(r), 0);
      idle(20); pix_gap(g); chk("R9", "pixel ratio 1 gap", g, 1);
      wr(1'b1, 32'd7);
      rd(1'b1, r); chk("R9", "pixel req 7 field", int'(r), 6);
      idle(20); pix_gap(g); chk("R9", "pixel ratio 7 gap", g, 7);
      pll_en = 1'b0;
      idle(5); pix_gap(g); chk("R7", "pixel unaffected", g, 7);
      pll_en = 1'b1;
      wr(1'b1, 32'd1000);
      rd(1'b1, r); chk("R9", "pixel req 1000 field", int'(r), 511);
      idle(20); pix_gap(g); chk("R9", "pixel clamp gap", g, 512);
      wr(1'b1, 32'd512);
      rd(1'b1, r); chk("R9", "pixel req 512 field", int'(r), 511);
      wr(1'b1, 32'd513);
      rd(1'b1, r); chk("R9", "pixel req 513 field", int'(r), 511);
      wr(1'b1, 32'd7);
      idle(600); pix_gap(g); chk("R9", "pixel back to 7", g, 7);

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule